// File: doc/BRIEF.md
# Reset Cause and Soft Reset Request Register

This block is a single 32-bit memory-mapped register that records why the system last went through reset, and lets software ask for a fresh reset. Five bits in the top of the word carry the state: a power-on cause, two soft request bits (power-on style and externally-initiated style), and two latched button causes. The cause bits are cleared by writing ones. The soft request bits are set by writing ones and cannot be cleared by software. Writing a soft request bit emits a one-cycle reset request toward the system's reset sequencer, together with a type bit.

The system returns a reset-event strobe each time a reset really happens. A saturating event counter lets the block tell a first reset after power-on (or after a soft power-on request, which zeroes the counter) from any later reset. Only the first one reloads the register with the power-on cause alone.

A small sequencer handles the request side. In state ST_IDLE, a write that sets either soft bit takes the transition IDLE->ISSUE. ST_ISSUE drives the request pulse for one cycle and takes ISSUE->AWAIT. ST_AWAIT holds until a reset event arrives and then takes AWAIT->IDLE. A reset event in ST_ISSUE takes ISSUE->IDLE directly. Any other condition holds the current state.

Top module: `rcc_reset_cause`

## Requirements
- R1: After the hardware reset is released, the register reads 0x00000000, `rst_req_o` is 0 and `rst_type_o` is 0.
- R2: The register responds only when the address lies in BASE..BASE+7 (default 0xF020..0xF027) and address bit 2 is 1. Reads elsewhere, including the lower word BASE..BASE+3, return zero. Writes elsewhere change nothing and raise no request.
- R3: Bit 31 is the power-on cause, bit 30 the soft power-on request, bit 29 the soft external request, bit 28 the button power-on cause and bit 27 the button external cause. Bits 26..0 always read zero and are ignored on write.
- R4: Writing a one to bit 31, 28 or 27 clears that bit. Writing a zero to it leaves it unchanged.
- R5: Writing a one to bit 30 or 29 sets that bit. Writing a zero leaves it unchanged. Only a power-on reload (R8) clears these bits.
- R6: A write with bit 30 set zeroes the event counter. If the sequencer is in ST_IDLE, the write raises `rst_req_o` in the cycle after the write edge, with `rst_type_o`=1 (power-on).
- R7: A write with bit 29 set and bit 30 clear, made in ST_IDLE, raises `rst_req_o` with `rst_type_o`=0 (external) and leaves the event counter unchanged.
- R8: On `rst_event_i`, if the event counter is zero, the register becomes exactly 0x80000000; otherwise the register keeps its value. The counter increments on every event.
- R9: The event counter saturates at its maximum value (2^CNT_W-1) and does not wrap. Any number of events after the first therefore never reloads the power-on cause.
- R10: `btn_por_i` sets bit 28 and `btn_xir_i` sets bit 27 at the next edge. A set wins over a same-cycle write that clears the bit.
- R11: The sequencer has states ST_IDLE, ST_ISSUE and ST_AWAIT with the transitions given above. Soft writes made in ST_ISSUE or ST_AWAIT update the bits but raise no new request, and `rst_type_o` holds its value outside ST_IDLE.
- R12: `rst_req_o` is high for exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| reg_addr_i | input | ADDR_W | Byte address of the access |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational from the address |
| btn_por_i | input | 1 | Button power-on cause event |
| btn_xir_i | input | 1 | Button external-reset cause event |
| rst_event_i | input | 1 | Strobe: a system reset has taken place |
| rst_req_o | output | 1 | One-cycle system reset request |
| rst_type_o | output | 1 | Request type: 1 power-on, 0 external |

## Verification
The decoder is swept over every byte address in a window around the register. Reads there separate the active upper word from the silent lower word and from its neighbours, and write attempts there show whether a stray address can clear bits or raise a request. All 32 write patterns over the five live bits are applied to a register with every bit set, which separates clear-on-one bits from set-only bits. Sequences of soft requests and reset events separate a counter that is zeroed by a soft power-on request from one that is left alone, and a long run of events separates saturation from wrap-around. Writes made during ST_AWAIT, and button events that coincide with clearing writes, check the request suppression and the set-over-clear priority.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
    localparam int REG_W  = 32;
    localparam int B_POR  = 31;
    localparam int B_SPOR = 30;
    localparam int B_SXIR = 29;
    localparam int B_BPOR = 28;
    localparam int B_BXIR = 27;

    localparam logic [REG_W-1:0] M_LIVE = 32'hF800_0000;
    localparam logic [REG_W-1:0] M_W1C  = 32'h9800_0000;
    localparam logic [REG_W-1:0] M_W1S  = 32'h6000_0000;
    localparam logic [REG_W-1:0] V_POR  = 32'h8000_0000;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_AWAIT = 2'd2
    } seq_state_e;

    typedef enum logic {
        RT_EXT     = 1'b0,
        RT_POWERON = 1'b1
    } rst_kind_e;
endpackage

// File: rtl/rcc_decode.sv
module rcc_decode #(
    parameter int                ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE   = 16'hF020
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              sel_hi_o
);
    localparam int TAG_LSB = 3;

    logic in_window;

    always_comb begin
        in_window = (addr_i[ADDR_W-1:TAG_LSB] == BASE[ADDR_W-1:TAG_LSB]);
        sel_hi_o  = in_window && addr_i[2];
    end
endmodule

// File: rtl/rcc_counter.sv
module rcc_counter #(
    parameter int CNT_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    output logic zero_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (inc_i && (cnt_q != CNT_MAX)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb zero_o = (cnt_q == '0);

    // R9: a saturated counter stays saturated unless cleared
    p_saturate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX && !clr_i) |=> (cnt_q == CNT_MAX));

    // R6: a soft power-on request leaves the counter at zero
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> zero_o);

    // R8: an event without clear never leaves the counter at zero
    p_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !clr_i) |=> !zero_o);
endmodule

// File: rtl/rcc_fsm.sv
module rcc_fsm
    import rcc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go_i,
    input  logic kind_i,
    input  logic event_i,
    output logic pulse_o,
    output logic kind_o
);
    seq_state_e state_q, state_d;
    rst_kind_e  kind_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (go_i) state_d = ST_ISSUE;
            end
            ST_ISSUE: begin
                if (event_i) state_d = ST_IDLE;
                else         state_d = ST_AWAIT;
            end
            ST_AWAIT: begin
                if (event_i) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            kind_q  <= RT_EXT;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && go_i) begin
                kind_q <= kind_i ? RT_POWERON : RT_EXT;
            end
        end
    end

    always_comb begin
        pulse_o = (state_q == ST_ISSUE);
        kind_o  = (kind_q == RT_POWERON);
    end

    // R12: the request pulse lasts exactly one cycle
    p_single_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> !pulse_o);

    // R11: the type output holds outside the idle state
    p_type_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(kind_o));

    // R11: a request accepted in idle is issued at the next edge
    p_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && go_i) |=> pulse_o);
endmodule

// File: rtl/rcc_reset_cause.sv
module rcc_reset_cause
    import rcc_pkg::*;
#(
    parameter int                ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE   = 16'hF020,
    parameter int                CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic              reg_wr_i,
    input  logic [31:0]       reg_wdata_i,
    output logic [31:0]       reg_rdata_o,
    input  logic              btn_por_i,
    input  logic              btn_xir_i,
    input  logic              rst_event_i,
    output logic              rst_req_o,
    output logic              rst_type_o
);
    logic              sel_hi;
    logic              wr_hit;
    logic [REG_W-1:0]  wv;
    logic              soft_por;
    logic              soft_xir;
    logic              cnt_zero;
    logic [REG_W-1:0]  cause_q, cause_d;

    rcc_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_decode (
        .addr_i   (reg_addr_i),
        .sel_hi_o (sel_hi)
    );

    always_comb begin
        wr_hit   = reg_wr_i && sel_hi;
        wv       = reg_wdata_i & M_LIVE;
        soft_por = wr_hit && wv[B_SPOR];
        soft_xir = wr_hit && wv[B_SXIR];
    end

    rcc_counter #(.CNT_W(CNT_W)) u_counter (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (soft_por),
        .inc_i  (rst_event_i),
        .zero_o (cnt_zero)
    );

    rcc_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .go_i    (soft_por || soft_xir),
        .kind_i  (soft_por),
        .event_i (rst_event_i),
        .pulse_o (rst_req_o),
        .kind_o  (rst_type_o)
    );

    always_comb begin
        cause_d = (rst_event_i && cnt_zero) ? V_POR : cause_q;
        if (wr_hit) begin
            cause_d = (cause_d & ~(wv & M_W1C)) | (wv & M_W1S);
        end
        if (btn_por_i) cause_d[B_BPOR] = 1'b1;
        if (btn_xir_i) cause_d[B_BXIR] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cause_q <= '0;
        else        cause_q <= cause_d;
    end

    always_comb reg_rdata_o = sel_hi ? cause_q : '0;

    // R8: first event after power-on or soft power-on reloads the power-on cause only
    p_por_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_event_i && cnt_zero && !wr_hit && !btn_por_i && !btn_xir_i)
        |=> (cause_q == V_POR));

    // R10: button events win over a same-cycle clear
    p_bpor_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        btn_por_i |=> cause_q[B_BPOR]);
    p_bxir_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        btn_xir_i |=> cause_q[B_BXIR]);

    // R5: soft bits survive everything except a reset event
    p_soft_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_q[B_SPOR] && !rst_event_i) |=> cause_q[B_SPOR]);

    // R3: unused bits never become set
    p_unused_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_q & ~M_LIVE) == '0);
endmodule

// File: tb/tb_rcc_reset_cause.sv
module tb_rcc_reset_cause;
    localparam int ADDR_W = 16;
    localparam int CNT_W  = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] reg_addr_i = '0;
    logic              reg_wr_i = 1'b0;
    logic [31:0]       reg_wdata_i = '0;
    logic [31:0]       reg_rdata_o;
    logic              btn_por_i = 1'b0;
    logic              btn_xir_i = 1'b0;
    logic              rst_event_i = 1'b0;
    logic              rst_req_o;
    logic              rst_type_o;

    int n_chk = 0;
    int n_bad = 0;
    logic p_seen, t_seen;
    int cycles = 0;

    rcc_reset_cause #(.ADDR_W(ADDR_W), .BASE(16'hF020), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .reg_addr_i(reg_addr_i), .reg_wr_i(reg_wr_i),
        .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
        .btn_por_i(btn_por_i), .btn_xir_i(btn_xir_i), .rst_event_i(rst_event_i),
        .rst_req_o(rst_req_o), .rst_type_o(rst_type_o)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_chk = n_chk + 1;
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    // one clock step with the given stimulus; captures pulse and type afterwards
    task automatic step(input logic wr, input logic [ADDR_W-1:0] a, input logic [31:0] d,
                        input logic bp, input logic bx, input logic ev);
        @(negedge clk);
        reg_wr_i = wr; reg_addr_i = a; reg_wdata_i = d;
        btn_por_i = bp; btn_xir_i = bx; rst_event_i = ev;
        @(negedge clk);
        reg_wr_i = 1'b0; btn_por_i = 1'b0; btn_xir_i = 1'b0; rst_event_i = 1'b0;
        p_seen = rst_req_o;
        t_seen = rst_type_o;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        reg_addr_i = a;
        #1;
        d = reg_rdata_o;
    endtask

    task automatic wr(input logic [31:0] d);
        step(1'b1, 16'hF024, d, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic evt();
        step(1'b0, 16'hF024, 32'h0, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic idle();
        step(1'b0, 16'hF024, 32'h0, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        logic [31:0] v;
        logic [31:0] exp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(16'hF024, v); chk("R1 reg", v, 32'h0);
        chk("R1 req", {31'b0, rst_req_o}, 32'h0);
        chk("R1 type", {31'b0, rst_type_o}, 32'h0);

        // R8 first event loads power-on cause, second keeps it
        evt(); rd(16'hF024, v); chk("R8 first event", v, 32'h8000_0000);
        evt(); rd(16'hF024, v); chk("R8 second event", v, 32'h8000_0000);
        wr(32'h8000_0000); rd(16'hF024, v); chk("R4 clear por", v, 32'h0);
        chk("R2 no req on clear", {31'b0, p_seen}, 32'h0);
        evt(); rd(16'hF024, v); chk("R8 no reload", v, 32'h0);

        // R7 soft external request
        wr(32'h2000_0000);
        chk("R7 pulse", {31'b0, p_seen}, 32'h1);
        chk("R7 type", {31'b0, t_seen}, 32'h0);
        rd(16'hF024, v); chk("R5 soft xir set", v, 32'h2000_0000);
        idle(); chk("R12 pulse ends", {31'b0, p_seen}, 32'h0);
        evt(); rd(16'hF024, v); chk("R7 counter kept", v, 32'h2000_0000);

        // R6 soft power-on request
        wr(32'h4000_0000);
        chk("R6 pulse", {31'b0, p_seen}, 32'h1);
        chk("R6 type", {31'b0, t_seen}, 32'h1);
        wr(32'h4000_0000);
        chk("R11 no pulse in issue", {31'b0, p_seen}, 32'h0);
        wr(32'h2000_0000);
        chk("R11 no pulse in await", {31'b0, p_seen}, 32'h0);
        chk("R11 type held", {31'b0, t_seen}, 32'h1);
        rd(16'hF024, v); chk("R5 both soft", v, 32'h6000_0000);
        evt(); rd(16'hF024, v); chk("R6 counter zeroed", v, 32'h8000_0000);

        // R3 all ones write
        wr(32'hFFFF_FFFF);
        chk("R6 both soft type", {31'b0, t_seen}, 32'h1);
        rd(16'hF024, v); chk("R3 live bits only", v, 32'h6000_0000);
        wr(32'h0); rd(16'hF024, v); chk("R5 zero write", v, 32'h6000_0000);
        evt(); rd(16'hF024, v); chk("R8 reload clears soft", v, 32'h8000_0000);

        // R2 address sweep; make the register rich first
        step(1'b0, 16'hF024, 32'h0, 1'b1, 1'b1, 1'b0);
        rd(16'hF024, v); chk("R10 buttons", v, 32'h9800_0000);
        for (int a = 16'hF000; a < 16'hF050; a++) begin
            logic hit;
            hit = (a >= 16'hF020) && (a <= 16'hF027) && a[2];
            rd(a[ADDR_W-1:0], v);
            chk($sformatf("R2 read %04h", a), v, hit ? 32'h9800_0000 : 32'h0);
            if (!hit) begin
                step(1'b1, a[ADDR_W-1:0], 32'hF800_0000, 1'b0, 1'b0, 1'b0);
                chk($sformatf("R2 no req %04h", a), {31'b0, p_seen}, 32'h0);
                rd(16'hF024, v);
                chk($sformatf("R2 no write %04h", a), v, 32'h9800_0000);
            end
        end
        step(1'b1, 16'hF027, 32'h0800_0000, 1'b0, 1'b0, 1'b0);
        rd(16'hF024, v); chk("R2 byte alias write", v, 32'h9000_0000);

        // R10 set wins over same-cycle clear
        step(1'b1, 16'hF024, 32'h1800_0000, 1'b1, 1'b0, 1'b0);
        rd(16'hF024, v); chk("R10 set wins", v, 32'h9000_0000);
        step(1'b1, 16'hF024, 32'h9000_0000, 1'b0, 1'b0, 1'b0);
        rd(16'hF024, v); chk("R4 w1c", v, 32'h0);
        evt(); rd(16'hF024, v); chk("R8 still counting", v, 32'h0);

        // R4 / R5 exhaustive over the five live bits
        wr(32'h4000_0000); evt();
        for (int p = 0; p < 32; p++) begin
            logic [31:0] pat;
            pat = 32'(p) << 27;
            wr(32'h6000_0000);
            step(1'b0, 16'hF024, 32'h0, 1'b1, 1'b1, 1'b0);
            rd(16'hF024, v); chk("R5 full setup", v, 32'hF800_0000);
            wr(pat | 32'h0000_1234);
            chk($sformatf("R11 await no pulse p%0d", p), {31'b0, p_seen}, 32'h0);
            exp = 32'hF800_0000 & ~(pat & 32'h9800_0000);
            rd(16'hF024, v); chk($sformatf("R4 pattern %0d", p), v, exp);
            evt();
            rd(16'hF024, v); chk($sformatf("R8 reload p%0d", p), v, 32'h8000_0000);
        end

        // R9 saturation: many events never reload
        wr(32'h8000_0000);
        for (int k = 0; k < 40; k++) begin
            evt();
            rd(16'hF024, v); chk($sformatf("R9 event %0d", k), v, 32'h0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule